// File: doc/BRIEF.md
# PCI Bridge Control and Status Register File

This block is the register front end of a system-bus-to-PCI bridge. A host reaches it through a plain register port. Each request carries a byte offset, a log2 access size, a write flag and write data. The block answers one clock later with read data and an error flag. It decides whether each offset and size pair is legal, trims written values to the bits that are actually built, and forces the hardwired zero bits on read-back.

The block holds several kinds of register. The interrupt group has address, mask, control, pending, level and two request views. The I/O group has the window enable, the I/O control, the back-to-back enable, the transfer-of-control (TOC) address and the config-address register. There is also a bank of twelve configuration registers, and each one has its own implemented width. From these registers the block drives a 32-bit forwarding-enable vector for the window remapper and a cleaned config address for the PCI configuration path. The PCI protocol, the remapping itself and interrupt delivery are handled elsewhere.

The block is a single-cycle request/response pipeline with no internal states. Write side effects happen at the clock edge where the request is sampled. The matching response appears on the outputs after that same edge.

Top module: `pci_bridge_csr`

## Requirements
- R1: The bank sits at offsets 0x800 to 0x82C, one register every 4 bytes. A write to bank index i stores only the low (w_i + 1) bits of the data, with w = 1, 7, 7, 8, 7, 9, 32, 8, 30, 25, 22, 9 for i = 0 to 11. A width of 32 keeps the full word.
- R2: Bank index 1 (offset 0x804) is the arbitration mask. Its bit 0 always reads as 0.
- R3: Bank index 7 (offset 0x81C) is the latency timer. Its bits 2:0 always read as 0.
- R4: Bank index 8 (offset 0x820) holds the feature bits. It reads back with bits 24, 15, 7, 6, 5 and 3 cleared.
- R5: The back-to-back enable register (0x028) stores only bits 1:0 of a write.
- R6: A write to the TOC register (0x02C) stores 0xFFFA0030 OR (data AND 0x0001E000). The register resets to 0xFFFA0030.
- R7: The level register (0x014) samples irq_lines every clock. The pending register (0x00C) gains each bit that rises on irq_lines. Any write to the pending register clears it to zero, whatever the data.
- R8: The level register and the request views at 0x018 and 0x01C ignore writes. 0x01C reads level AND mask (0x008) AND control (0x010). 0x018 reads level AND control AND NOT mask.
- R9: Access size is log2 bytes (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). In the I/O data window, offset 0x040 accepts any size, 0x042 accepts sizes 0 and 1, and 0x041 and 0x043 accept size 0 only. The window itself reads zero. Every word register offset accepts any size. All other offsets are errors. An errored access reads zero and changes no state.
- R10: The config-address register (0x030) reads back the full written word. cfg_addr_out carries the same word with bits 1:0 cleared.
- R11: fwd_en equals the I/O enable register (0x024) AND 0x7FFFFFFE when bits 8:7 of the I/O control register (0x020) equal 2'b01. Otherwise fwd_en is all zero.
- R12: After reset, both interrupt address registers (0x000, 0x004) hold CPU_BASE + 3 and TOC holds 0xFFFA0030. Every other register, fwd_en and rsp_valid are zero.
- R13: Every request sampled with req_valid high gives rsp_valid, rsp_rdata and rsp_err on the next clock. A write's response carries zero data. A write is visible to a read issued on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Log2 of access size in bytes |
| req_wdata | input | 32 | Write data |
| irq_lines | input | 32 | Interrupt source levels |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Illegal offset or size |
| fwd_en | output | 32 | Per-window forwarding enables |
| cfg_addr_out | output | 32 | Config address with bits 1:0 cleared |

## Verification
The bench writes several patterns to each of the twelve bank registers and computes the kept bits and the forced-zero bits arithmetically. A design with a shifted width or a lost read mask would show stray high bits or a missing zero bit. It sweeps every offset around the register group, the I/O window and the bank, at all four sizes. This catches a design that accepts a wide access at bytes 1 to 3 of the I/O window or accepts unaligned bank offsets. It also checks that errored reads return zero and errored writes leave state untouched. It covers the pending clear with non-zero data, writes to the read-only views, the TOC merge, the untrimmed config read-back, and all four encodings of the forwarding field. A design that forwards window 0 or 31 would show those bits set.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int BANK_N   = 12;
    localparam int BANK_IW  = $clog2(BANK_N);

    localparam logic [31:0] TOC_FIXED = 32'hFFFA_0030;
    localparam logic [31:0] TOC_KEEP  = 32'h0001_E000;
    localparam logic [31:0] FWD_MASK  = 32'h7FFF_FFFE;
    localparam logic [31:0] FEAT_RSVD = 32'h0100_80E8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IAR0,
        SEL_IAR1,
        SEL_IMR,
        SEL_IPR,
        SEL_ICR,
        SEL_ILR,
        SEL_IRQ_REQ0,
        SEL_IRQ_REQ1,
        SEL_IOCTL,
        SEL_IOEN,
        SEL_B2B,
        SEL_TOC,
        SEL_CFGA,
        SEL_IODATA,
        SEL_BANK
    } csr_sel_e;

    // Highest implemented bit index for each bank register.
    function automatic int bank_top_bit(input int idx);
        case (idx)
            0:       return 1;
            1:       return 7;
            2:       return 7;
            3:       return 8;
            4:       return 7;
            5:       return 9;
            6:       return 32;
            7:       return 8;
            8:       return 30;
            9:       return 25;
            10:      return 22;
            default: return 9;
        endcase
    endfunction

    function automatic logic [31:0] bank_keep(input int idx);
        int t;
        t = bank_top_bit(idx);
        if (t >= 31) return 32'hFFFF_FFFF;
        return (32'h1 << (t + 1)) - 32'h1;
    endfunction

    // Bits forced to zero when the bank register is read.
    function automatic logic [31:0] bank_rd_zero(input int idx);
        case (idx)
            1:       return 32'h0000_0001;
            7:       return 32'h0000_0007;
            8:       return FEAT_RSVD;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/pbc_decode.sv
module pbc_decode
    import pbc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         size,
    output csr_sel_e           sel,
    output logic [BANK_IW-1:0] bank_idx,
    output logic               legal
);
    localparam logic [ADDR_W-1:0] BANK_LO = ADDR_W'(12'h800);
    localparam logic [ADDR_W-1:0] BANK_HI = ADDR_W'(12'h800 + 4 * BANK_N);

    always_comb begin
        sel      = SEL_NONE;
        bank_idx = '0;
        legal    = 1'b0;
        if (addr >= BANK_LO && addr < BANK_HI && addr[1:0] == 2'b00) begin
            sel      = SEL_BANK;
            bank_idx = BANK_IW'((addr - BANK_LO) >> 2);
            legal    = 1'b1;
        end else begin
            unique case (addr)
                ADDR_W'(12'h000): sel = SEL_IAR0;
                ADDR_W'(12'h004): sel = SEL_IAR1;
                ADDR_W'(12'h008): sel = SEL_IMR;
                ADDR_W'(12'h00C): sel = SEL_IPR;
                ADDR_W'(12'h010): sel = SEL_ICR;
                ADDR_W'(12'h014): sel = SEL_ILR;
                ADDR_W'(12'h018): sel = SEL_IRQ_REQ0;
                ADDR_W'(12'h01C): sel = SEL_IRQ_REQ1;
                ADDR_W'(12'h020): sel = SEL_IOCTL;
                ADDR_W'(12'h024): sel = SEL_IOEN;
                ADDR_W'(12'h028): sel = SEL_B2B;
                ADDR_W'(12'h02C): sel = SEL_TOC;
                ADDR_W'(12'h030): sel = SEL_CFGA;
                ADDR_W'(12'h040): sel = SEL_IODATA;
                ADDR_W'(12'h042): sel = (size <= 2'd1) ? SEL_IODATA : SEL_NONE;
                ADDR_W'(12'h041),
                ADDR_W'(12'h043): sel = (size == 2'd0) ? SEL_IODATA : SEL_NONE;
                default:          sel = SEL_NONE;
            endcase
            legal = (sel != SEL_NONE);
        end
    end
endmodule

// File: rtl/pbc_cfg_bank.sv
module pbc_cfg_bank
    import pbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BANK_IW-1:0] idx,
    input  logic [31:0]        wdata,
    output logic [31:0]        rd_data
);
    logic [31:0] store [BANK_N];

    for (genvar i = 0; i < BANK_N; i++) begin : g_reg
        localparam logic [31:0] KEEP = bank_keep(i);

        always_ff @(posedge clk) begin
            if (!rst_n)
                store[i] <= '0;
            else if (wr_en && idx == BANK_IW'(i))
                store[i] <= wdata & KEEP;
        end

        assert_bank_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && idx == BANK_IW'(i)) |=> (store[i] == ($past(wdata) & KEEP)));
    end

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < BANK_N; j++)
            if (idx == BANK_IW'(j))
                rd_data = store[j] & ~bank_rd_zero(j);
    end
endmodule

// File: rtl/pbc_irq_regs.sv
module pbc_irq_regs
    import pbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_lines,
    input  logic        wr_en,
    input  csr_sel_e    sel,
    input  logic [31:0] wdata,
    output logic [31:0] imr,
    output logic [31:0] icr,
    output logic [31:0] ipr,
    output logic [31:0] ilr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr <= '0;
            icr <= '0;
            ipr <= '0;
            ilr <= '0;
        end else begin
            ilr <= irq_lines;
            if (wr_en && sel == SEL_IPR)
                ipr <= '0;
            else
                ipr <= ipr | (irq_lines & ~ilr);
            if (wr_en && sel == SEL_IMR) imr <= wdata;
            if (wr_en && sel == SEL_ICR) icr <= wdata;
        end
    end

    assert_pending_wipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_IPR) |=> (ipr == '0));

    assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ilr == $past(irq_lines)));
endmodule

// File: rtl/pci_bridge_csr.sv
module pci_bridge_csr
    import pbc_pkg::*;
#(
    parameter logic [31:0] CPU_BASE = 32'hFFFE_0000,
    parameter int          ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       irq_lines,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic [31:0]       fwd_en,
    output logic [31:0]       cfg_addr_out
);
    localparam logic [31:0] IAR_RESET = CPU_BASE + 32'd3;

    csr_sel_e           sel;
    logic [BANK_IW-1:0] bank_idx;
    logic               legal;
    logic               wr_ok;
    logic [31:0]        bank_rd;
    logic [31:0]        imr, icr, ipr, ilr;
    logic [31:0]        iar0, iar1, io_ctl, io_en, b2b, toc, cfga;
    logic [31:0]        rd_mux;

    pbc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (req_addr),
        .size     (req_size),
        .sel      (sel),
        .bank_idx (bank_idx),
        .legal    (legal)
    );

    assign wr_ok = req_valid && req_write && legal;

    pbc_cfg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && sel == SEL_BANK),
        .idx     (bank_idx),
        .wdata   (req_wdata),
        .rd_data (bank_rd)
    );

    pbc_irq_regs u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .wr_en     (wr_ok),
        .sel       (sel),
        .wdata     (req_wdata),
        .imr       (imr),
        .icr       (icr),
        .ipr       (ipr),
        .ilr       (ilr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iar0   <= IAR_RESET;
            iar1   <= IAR_RESET;
            io_ctl <= '0;
            io_en  <= '0;
            b2b    <= '0;
            toc    <= TOC_FIXED;
            cfga   <= '0;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_IAR0:  iar0   <= req_wdata;
                SEL_IAR1:  iar1   <= req_wdata;
                SEL_IOCTL: io_ctl <= req_wdata;
                SEL_IOEN:  io_en  <= req_wdata;
                SEL_B2B:   b2b    <= {30'd0, req_wdata[1:0]};
                SEL_TOC:   toc    <= TOC_FIXED | (req_wdata & TOC_KEEP);
                SEL_CFGA:  cfga   <= req_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_IAR0:     rd_mux = iar0;
            SEL_IAR1:     rd_mux = iar1;
            SEL_IMR:      rd_mux = imr;
            SEL_IPR:      rd_mux = ipr;
            SEL_ICR:      rd_mux = icr;
            SEL_ILR:      rd_mux = ilr;
            SEL_IRQ_REQ0: rd_mux = ilr & icr & ~imr;
            SEL_IRQ_REQ1: rd_mux = ilr & imr & icr;
            SEL_IOCTL:    rd_mux = io_ctl;
            SEL_IOEN:     rd_mux = io_en;
            SEL_B2B:      rd_mux = b2b;
            SEL_TOC:      rd_mux = toc;
            SEL_CFGA:     rd_mux = cfga;
            SEL_BANK:     rd_mux = bank_rd;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= (req_valid && !req_write && legal) ? rd_mux : '0;
        end
    end

    assign fwd_en       = (io_ctl[8:7] == 2'b01) ? (io_en & FWD_MASK) : '0;
    assign cfg_addr_out = cfga & ~32'h3;

    assert_toc_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((toc & ~TOC_KEEP) == TOC_FIXED));

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    assert_io_odd_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == ADDR_W'(12'h041) && req_size != 2'd0) |=> rsp_err);

    assert_cfg_trim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel == SEL_CFGA) |=> (cfg_addr_out == ($past(req_wdata) & ~32'h3)));

    assert_fwd_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ctl[8:7] != 2'b01) |-> (fwd_en == '0));

    assert_rsp_next_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
endmodule

// File: tb/pci_bridge_csr_tb.sv
module pci_bridge_csr_tb;
    localparam logic [31:0] BASE = 32'h1234_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] irq_lines = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [31:0] fwd_en;
    logic [31:0] cfg_addr_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pci_bridge_csr #(.CPU_BASE(BASE), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .irq_lines(irq_lines), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .fwd_en(fwd_en), .cfg_addr_out(cfg_addr_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample the response at the next falling edge.
    task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] d, output logic [31:0] rd, output logic er);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R13 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er;
        access(1'b1, a, 2'd2, d, rd, er);
        chk("R13 write data zero", rd, 32'h0);
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] v);
        logic er;
        access(1'b0, a, 2'd2, 32'h0, v, er);
    endtask

    function automatic logic [31:0] keep_of(input int i);
        int w[12] = '{1, 7, 7, 8, 7, 9, 32, 8, 30, 25, 22, 9};
        if (w[i] >= 31) return 32'hFFFF_FFFF;
        return (32'h1 << (w[i] + 1)) - 1;
    endfunction

    function automatic logic [31:0] zero_of(input int i);
        if (i == 1) return 32'h1;
        if (i == 7) return 32'h7;
        if (i == 8) return (32'h1 << 24) | (32'h1 << 15) | (32'h1 << 7)
                         | (32'h1 << 6) | (32'h1 << 5) | (32'h1 << 3);
        return 32'h0;
    endfunction

    function automatic bit legal_of(input int a, input int sz);
        if (a >= 'h800 && a < 'h830 && a % 4 == 0) return 1;
        if (a <= 'h030 && a % 4 == 0) return 1;
        if (a == 'h040) return 1;
        if (a == 'h042) return sz <= 1;
        if (a == 'h041 || a == 'h043) return sz == 0;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, pat, ilr_e, imr_v, icr_v;
        logic er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        chk("R12 fwd_en", fwd_en, 32'd0);
        rd32(12'h000, v); chk("R12 iar0", v, BASE + 3);
        rd32(12'h004, v); chk("R12 iar1", v, BASE + 3);
        rd32(12'h02C, v); chk("R12 toc", v, 32'hFFFA_0030);
        rd32(12'h008, v); chk("R12 imr", v, 32'h0);
        rd32(12'h030, v); chk("R12 cfga", v, 32'h0);
        for (int i = 0; i < 12; i++) begin
            rd32(12'h800 + 12'(4 * i), v); chk("R12 bank", v, 32'h0);
        end

        // R1..R4 bank width and read-zero bits, several patterns
        for (int p = 0; p < 4; p++) begin
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5A5_5A5A :
                  (p == 2) ? 32'h8000_01FF : 32'h1357_9BDF;
            for (int i = 0; i < 12; i++)
                wr32(12'h800 + 12'(4 * i), pat ^ 32'(i * 32'h0101_0101));
            for (int i = 0; i < 12; i++) begin
                rd32(12'h800 + 12'(4 * i), v);
                chk(i == 1 ? "R2 arb bit0" : i == 7 ? "R3 latency low" :
                    i == 8 ? "R4 feature rsvd" : "R1 bank width",
                    v, (pat ^ 32'(i * 32'h0101_0101)) & keep_of(i) & ~zero_of(i));
            end
        end

        // R5 back-to-back enable
        wr32(12'h028, 32'hFFFF_FFFF); rd32(12'h028, v); chk("R5 b2b", v, 32'h3);
        wr32(12'h028, 32'h0000_0006); rd32(12'h028, v); chk("R5 b2b", v, 32'h2);

        // R6 TOC merge
        wr32(12'h02C, 32'hFFFF_FFFF); rd32(12'h02C, v);
        chk("R6 toc", v, 32'hFFFA_0030 | (32'hF << 13));
        wr32(12'h02C, 32'h0000_2000); rd32(12'h02C, v);
        chk("R6 toc", v, 32'hFFFA_0030 | 32'h2000);

        // R10 config address
        wr32(12'h030, 32'h8000_1237); rd32(12'h030, v);
        chk("R10 cfga readback", v, 32'h8000_1237);
        chk("R10 cfg_addr_out", cfg_addr_out, 32'h8000_1234);

        // R7 / R8 interrupt group
        imr_v = 32'h0F0F_0F0F; icr_v = 32'h00FF_FF00; ilr_e = 32'h3333_3333;
        wr32(12'h008, imr_v);
        wr32(12'h010, icr_v);
        irq_lines = ilr_e;
        @(negedge clk);
        rd32(12'h014, v); chk("R7 level", v, ilr_e);
        rd32(12'h00C, v); chk("R7 pending capture", v, ilr_e);
        rd32(12'h01C, v); chk("R8 request1", v, ilr_e & imr_v & icr_v);
        rd32(12'h018, v); chk("R8 request0", v, ilr_e & icr_v & ~imr_v);
        wr32(12'h00C, 32'hFFFF_FFFF); rd32(12'h00C, v); chk("R7 pending clear", v, 32'h0);
        wr32(12'h014, 32'h0); rd32(12'h014, v); chk("R8 level ro", v, ilr_e);
        wr32(12'h01C, 32'h0); rd32(12'h01C, v); chk("R8 request1 ro", v, ilr_e & imr_v & icr_v);
        wr32(12'h018, 32'hFFFF_FFFF); rd32(12'h018, v); chk("R8 request0 ro", v, ilr_e & icr_v & ~imr_v);
        irq_lines = ilr_e | 32'h0000_0004;
        @(negedge clk);
        rd32(12'h00C, v); chk("R7 pending new edge", v, 32'h0000_0004);

        // R11 forwarding
        wr32(12'h024, 32'hFFFF_FFFF);
        for (int c = 0; c < 4; c++) begin
            wr32(12'h020, 32'(c) << 7);
            chk("R11 fwd_en", fwd_en, (c == 1) ? 32'h7FFF_FFFE : 32'h0);
        end
        wr32(12'h024, 32'h8000_0013);
        wr32(12'h020, 32'h80);
        chk("R11 fwd_en edges", fwd_en, 32'h0000_0012);

        // R9 legality sweep over reads
        for (int a = 0; a < 'h60; a++)
            for (int s = 0; s < 4; s++) begin
                access(1'b0, 12'(a), 2'(s), 32'h0, v, er);
                chk("R9 legality", {31'd0, er}, {31'd0, ~legal_of(a, s)});
                if (!legal_of(a, s) || (a >= 'h40 && a <= 'h43)) chk("R9 zero data", v, 32'h0);
            end
        for (int a = 'h7F0; a < 'h840; a++)
            for (int s = 0; s < 4; s++) begin
                access(1'b0, 12'(a), 2'(s), 32'h0, v, er);
                chk("R9 legality bank", {31'd0, er}, {31'd0, ~legal_of(a, s)});
                if (!legal_of(a, s)) chk("R9 zero data", v, 32'h0);
            end

        // R9 errored writes have no effect
        wr32(12'h818, 32'h1111_2222);
        access(1'b1, 12'h819, 2'd2, 32'hFFFF_FFFF, v, er);
        chk("R9 err flagged", {31'd0, er}, 32'd1);
        access(1'b1, 12'h01A, 2'd2, 32'hFFFF_FFFF, v, er);
        access(1'b1, 12'h043, 2'd1, 32'hFFFF_FFFF, v, er);
        chk("R9 err io size", {31'd0, er}, 32'd1);
        rd32(12'h818, v); chk("R9 err write ignored", v, 32'h1111_2222);
        rd32(12'h8FC, v); chk("R9 err write ignored toc", v, 32'h0);
        rd32(12'h02C, v); chk("R9 toc intact", v, 32'hFFFA_0030 | 32'h2000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule